// File: doc/BRIEF.md
# Byte-Wide Three-Wire Serial Shifter

This block moves one byte at a time over a synchronous serial link made of a clock line, a data-in line and a data-out line. The byte goes out and a byte comes in during the same transfer. A small register port lets a host processor set the mode and load the byte. Writing the byte starts the transfer, and the host can read the received byte back from the same register once the transfer is done.

The bit order is chosen at run time, least or most significant bit first, and the same order applies in both directions. Outgoing bits change on falling serial-clock edges and incoming bits are captured on rising edges. In master mode the block makes the serial clock itself by dividing the system clock. In slave mode it follows an external serial clock, which it brings into the system clock domain through a synchronizer. A single-cycle interrupt pulse marks the end of each byte. Clearing the enable bit stops a transfer at once. A byte write that arrives while a transfer is running is discarded and reported on a one-cycle flag.

Top module: `tri_wire_shifter`

## Requirements
- R1: When the block is idle and `reg_sel`=0, a write stores `reg_wdata` in the data register. If the enable bit is set, `busy` rises on the next cycle and stays high until the byte completes or is aborted.
- R2: In master mode `sck_oe` is 1 and `sck_o` idles high. The first falling edge of `sck_o` comes HALF_DIV system cycles after the starting write, and each later half period also lasts HALF_DIV cycles. After the 8th rising edge `sck_o` stays high until the next start.
- R3: Each falling serial-clock edge drives one transmit bit on `so`. With the order bit at 0 the bits go out from bit 7 down to bit 0; with the order bit at 1 they go from bit 0 up to bit 7. `so` never changes while the block is idle.
- R4: Each rising serial-clock edge captures one bit from `si`, in the same order as transmission. After the 8th rising edge, `rd_data` holds the received byte, with the first captured bit in bit 7 (order bit 0) or in bit 0 (order bit 1).
- R5: `done_irq` is high for exactly one cycle. That cycle follows the system edge that handled the 8th rising serial-clock edge, and `busy` is low in it.
- R6: A data write while `busy` is high is ignored, and the transfer finishes with its original bits. `wr_collide` is high for exactly the following cycle.
- R7: A control write (`reg_sel`=1) with the enable bit (bit 0) at 0 aborts at once. On the next cycle `busy` is 0 and `sck_o` is 1, and no `done_irq` follows.
- R8: In slave mode (control bit 2 = 0) `sck_oe` is 0. `sck_i` passes through SYNC_N flip-flops before its edges are used. A rising edge that arrives after a start but before the first falling edge is ignored.
- R9: A data write while the enable bit is 0 loads `rd_data` but starts nothing: `busy` stays 0 and `sck_o` stays high.
- R10: After reset `busy`, `done_irq`, `wr_collide`, `sck_oe` and `rd_data` are 0, and `sck_o` and `so` are 1.

Control word layout: bit 0 is enable, bit 1 is the order (1 means least significant bit first), and bit 2 selects master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the data register, 1 selects the control word |
| reg_wdata | input | DW | Write data |
| rd_data | output | DW | Data register contents (the received byte once a transfer ends) |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle end-of-byte interrupt pulse |
| wr_collide | output | 1 | One-cycle flag for a data write rejected during a transfer |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for the serial clock (high in master mode) |
| sck_i | input | 1 | External serial clock used in slave mode |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |

## Verification
The bench checks that the first falling clock edge comes exactly HALF_DIV cycles after the write. A divider that started counting one cycle late would shift every bit and fail the per-cycle model comparison. It runs both bit orders in both modes, so a design that reversed the receive order but not the transmit order would return a mirrored byte. It also writes a new byte in the middle of a transfer and expects the original bits on `so`; a design that reloaded the shifter would emit the wrong bits. An abort part-way through the byte must drop `busy` and park the clock high with no interrupt, and a slave transfer that begins with the clock low must ignore its first rising edge rather than count it as bit one.

// File: rtl/tws_pkg.sv
package tws_pkg;
    // Control word bit positions
    localparam int CTRL_EN  = 0;
    localparam int CTRL_LSB = 1;
    localparam int CTRL_MST = 2;

    // Register select values
    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    // Serial clock edge events seen in the system clock domain
    typedef struct packed {
        logic fall;
        logic rise;
    } sck_edge_t;
endpackage

// File: rtl/tws_sck_div.sv
module tws_sck_div
    import tws_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    output logic      sck,
    output sck_edge_t evt_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == LAST);
        if (!run) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b1;
        end else if (tick) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, lvl: 1'b1};
        else        st_q <= st_d;
    end

    assign sck   = st_q.lvl;
    assign evt_o = '{fall: tick & st_q.lvl, rise: tick & ~st_q.lvl};
endmodule

// File: rtl/tws_sck_sync.sv
module tws_sck_sync
    import tws_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sck_in,
    output sck_edge_t evt_o
);
    // pipe[0..SYNC_N-1] synchronize, pipe[SYNC_N] holds the previous level
    logic [SYNC_N:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[SYNC_N-1:0], sck_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign evt_o = '{fall: pipe_q[SYNC_N] & ~pipe_q[SYNC_N-1],
                     rise: ~pipe_q[SYNC_N] & pipe_q[SYNC_N-1]};
endmodule

// File: rtl/tri_wire_shifter.sv
module tri_wire_shifter
    import tws_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HALF_DIV = 4,
    parameter int SYNC_N   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done_irq,
    output logic          wr_collide,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          sck_i,
    input  logic          si,
    output logic          so
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

    typedef struct packed {
        logic             en;
        logic             lsb;
        logic             mst;
        logic [DW-1:0]    sh;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             busy;
        logic             so;
        logic             irq;
        logic             col;
    } st_t;

    st_t       st_d, st_q;
    sck_edge_t gen_evt, ext_evt, evt;
    logic      gen_sck;

    tws_sck_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.busy & st_q.mst),
        .sck   (gen_sck),
        .evt_o (gen_evt)
    );

    tws_sck_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_in (sck_i),
        .evt_o  (ext_evt)
    );

    assign evt = st_q.mst ? gen_evt : ext_evt;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.col = 1'b0;

        // Launch a bit on a falling serial edge
        if (st_q.busy && evt.fall) begin
            st_d.so    = st_q.lsb ? st_q.sh[0] : st_q.sh[DW-1];
            st_d.armed = 1'b1;
        end

        // Capture a bit on a rising edge that follows a launch
        if (st_q.busy && evt.rise && st_q.armed) begin
            st_d.sh    = st_q.lsb ? {si, st_q.sh[DW-1:1]} : {st_q.sh[DW-2:0], si};
            st_d.armed = 1'b0;
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt  = '0;
                st_d.busy = 1'b0;
                st_d.irq  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        // Data register write
        if (reg_we && reg_sel == SEL_DATA) begin
            if (st_q.busy) begin
                st_d.col = 1'b1;
            end else begin
                st_d.sh = reg_wdata;
                if (st_q.en) begin
                    st_d.busy  = 1'b1;
                    st_d.cnt   = '0;
                    st_d.armed = 1'b0;
                end
            end
        end

        // Control word write; clearing enable aborts
        if (reg_we && reg_sel == SEL_CTRL) begin
            st_d.en  = reg_wdata[CTRL_EN];
            st_d.lsb = reg_wdata[CTRL_LSB];
            st_d.mst = reg_wdata[CTRL_MST];
            if (!reg_wdata[CTRL_EN]) begin
                st_d.busy  = 1'b0;
                st_d.cnt   = '0;
                st_d.armed = 1'b0;
                st_d.irq   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, lsb: 1'b0, mst: 1'b0, sh: '0, cnt: '0,
                      armed: 1'b0, busy: 1'b0, so: 1'b1, irq: 1'b0, col: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.sh;
    assign busy       = st_q.busy;
    assign done_irq   = st_q.irq;
    assign wr_collide = st_q.col;
    assign so         = st_q.so;
    assign sck_oe     = st_q.mst;
    assign sck_o      = st_q.mst ? (gen_sck | ~st_q.busy) : 1'b1;
endmodule

// File: rtl/tws_props.sv
module tws_props
    import tws_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic          reg_sel,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] rd_data,
    input logic          busy,
    input logic          done_irq,
    input logic          wr_collide,
    input logic          sck_o,
    input logic          so,
    input logic          en_i
);
    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_DATA && !busy && en_i) |=> busy);

    // R3
    so_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(so));

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R5
    irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!busy && $past(busy)));

    // R6
    collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_DATA && busy) |=> wr_collide);

    // R7
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_CTRL && !reg_wdata[CTRL_EN]) |=> (!busy && sck_o && !done_irq));

    // R9
    disabled_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_DATA && !busy && !en_i) |=> (!busy && rd_data == $past(reg_wdata)));
endmodule

bind tri_wire_shifter tws_props #(.DW(DW)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .rd_data    (rd_data),
    .busy       (busy),
    .done_irq   (done_irq),
    .wr_collide (wr_collide),
    .sck_o      (sck_o),
    .so         (so),
    .en_i       (st_q.en)
);

// File: tb/tri_wire_shifter_bench.sv
module tri_wire_shifter_bench;
    localparam int DW   = 8;
    localparam int HALF = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic          reg_sel = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic          sck_i = 1'b1;
    logic          si = 1'b0;
    logic [DW-1:0] rd_data;
    logic          busy, done_irq, wr_collide, sck_o, sck_oe, so;

    always #4 clk = ~clk;

    tri_wire_shifter #(.DW(DW), .HALF_DIV(HALF), .SYNC_N(2)) u_tri_wire_shifter (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .busy(busy),
        .done_irq(done_irq), .wr_collide(wr_collide), .sck_o(sck_o),
        .sck_oe(sck_oe), .sck_i(sck_i), .si(si), .so(so)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit         m_en, m_lsb, m_mst, m_armed, m_busy, m_so, m_irq, m_col, m_sck;
    bit [7:0]   m_reg;
    int         m_bits, m_div;
    bit [2:0]   m_sy;

    always @(posedge clk or negedge rst_n) begin
        bit run, tick, f, r;
        if (!rst_n) begin
            m_en = 0; m_lsb = 0; m_mst = 0; m_reg = 0; m_bits = 0; m_armed = 0;
            m_busy = 0; m_so = 1; m_irq = 0; m_col = 0; m_div = 0; m_sck = 1; m_sy = 3'b111;
        end else begin
            run  = m_busy && m_mst;
            tick = run && (m_div == HALF - 1);
            if (m_mst) begin f = tick && m_sck; r = tick && !m_sck; end
            else begin f = m_sy[2] && !m_sy[1]; r = !m_sy[2] && m_sy[1]; end
            if (!run) begin m_div = 0; m_sck = 1; end
            else if (tick) begin m_div = 0; m_sck = !m_sck; end
            else m_div++;
            m_sy = {m_sy[1:0], sck_i};
            m_irq = 0; m_col = 0;
            if (m_busy && f) begin m_so = m_lsb ? m_reg[0] : m_reg[7]; m_armed = 1; end
            if (m_busy && r && m_armed) begin
                m_reg = m_lsb ? {si, m_reg[7:1]} : {m_reg[6:0], si};
                m_armed = 0; m_bits++;
                if (m_bits == 8) begin m_bits = 0; m_busy = 0; m_irq = 1; end
            end
            if (reg_we && !reg_sel) begin
                if (m_busy) m_col = 1;
                else begin
                    m_reg = reg_wdata;
                    if (m_en) begin m_busy = 1; m_bits = 0; m_armed = 0; end
                end
            end
            if (reg_we && reg_sel) begin
                m_en = reg_wdata[0]; m_lsb = reg_wdata[1]; m_mst = reg_wdata[2];
                if (!m_en) begin m_busy = 0; m_bits = 0; m_armed = 0; m_irq = 0; end
            end
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == m_busy, "R1 busy vs model", busy, m_busy);
            chk(sck_o == (m_mst ? (m_sck | !m_busy) : 1'b1), "R2 sck_o vs model",
                sck_o, m_mst ? (m_sck | !m_busy) : 1'b1);
            chk(sck_oe == m_mst, "R8 sck_oe vs model", sck_oe, m_mst);
            chk(so == m_so, "R3 so vs model", so, m_so);
            chk(rd_data == m_reg, "R4 rd_data vs model", rd_data, m_reg);
            chk(done_irq == m_irq, "R5 irq vs model", done_irq, m_irq);
            chk(wr_collide == m_col, "R6 collide vs model", wr_collide, m_col);
        end
    end

    // ---------------- stimulus helpers ----------------
    int irq_cnt = 0;
    int col_cnt = 0;
    always @(negedge clk) begin
        if (done_irq) irq_cnt++;
        if (wr_collide) col_cnt++;
    end

    logic [7:0] resp;
    bit         resp_lsb, resp_on, cap_on;
    int         ridx;
    bit         cap[$];

    always @(negedge sck_o) begin
        if (resp_on && ridx < 8) begin
            si = resp_lsb ? resp[ridx] : resp[7 - ridx];
            ridx++;
        end
    end

    always @(posedge sck_o) begin
        if (cap_on) cap.push_back(so);
    end

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done_irq) begin seen = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    task automatic check_cap(input logic [7:0] tx, input bit lsb, input string tag);
        chk(cap.size() == 8, tag, cap.size(), 8);
        if (cap.size() == 8)
            for (int i = 0; i < 8; i++)
                chk(cap[i] == (lsb ? tx[i] : tx[7 - i]), tag, cap[i], lsb ? tx[i] : tx[7 - i]);
    endtask

    task automatic run_master(input logic [7:0] tx, input logic [7:0] rx, input bit lsb);
        bit seen;
        int irq0;
        cap.delete(); resp = rx; resp_lsb = lsb; ridx = 0; resp_on = 1; cap_on = 1;
        wr(1'b1, {5'b0, 1'b1, lsb, 1'b1});
        chk(sck_oe == 1'b1, "R2 sck_oe in master", sck_oe, 1);
        irq0 = irq_cnt;
        wr(1'b0, tx);
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        repeat (HALF - 1) @(negedge clk);
        chk(sck_o == 1'b1, "R2 high before first fall", sck_o, 1);
        @(negedge clk);
        chk(sck_o == 1'b0, "R2 first fall after HALF_DIV", sck_o, 0);
        wait_irq(seen);
        chk(seen, "R5 irq seen", seen, 1);
        chk(busy == 1'b0, "R5 busy low with irq", busy, 0);
        chk(rd_data == rx, "R4 received byte", rd_data, rx);
        check_cap(tx, lsb, "R3 transmit order");
        repeat (12) @(negedge clk);
        chk(sck_o == 1'b1, "R2 clock parked high", sck_o, 1);
        chk(irq_cnt == irq0 + 1, "R5 single irq", irq_cnt, irq0 + 1);
        resp_on = 0; cap_on = 0;
    endtask

    task automatic run_slave(input logic [7:0] tx, input logic [7:0] rx, input bit lsb, input bit pre_low);
        logic [7:0] got;
        int irq0;
        wr(1'b1, {5'b0, 1'b0, lsb, 1'b1});
        chk(sck_oe == 1'b0, "R8 sck_oe in slave", sck_oe, 0);
        if (pre_low) begin sck_i = 1'b0; repeat (6) @(negedge clk); end
        irq0 = irq_cnt;
        wr(1'b0, tx);
        if (pre_low) begin
            repeat (6) @(negedge clk);
            sck_i = 1'b1;           // R8: this rise precedes any fall
            repeat (6) @(negedge clk);
        end
        for (int b = 0; b < 8; b++) begin
            sck_i = 1'b0;
            si = lsb ? rx[b] : rx[7 - b];
            repeat (5) @(negedge clk);
            sck_i = 1'b1;
            got[b] = so;
            repeat (5) @(negedge clk);
        end
        for (int i = 0; i < 8; i++)
            chk(got[i] == (lsb ? tx[i] : tx[7 - i]), "R8 slave transmit bit", got[i], lsb ? tx[i] : tx[7 - i]);
        chk(rd_data == rx, "R8 slave received byte", rd_data, rx);
        chk(busy == 1'b0, "R8 slave idle after byte", busy, 0);
        chk(irq_cnt == irq0 + 1, "R5 slave irq once", irq_cnt, irq0 + 1);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        bit seen;
        int irq0, col0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(busy == 0, "R10 busy", busy, 0);
        chk(done_irq == 0, "R10 irq", done_irq, 0);
        chk(wr_collide == 0, "R10 collide", wr_collide, 0);
        chk(sck_oe == 0, "R10 sck_oe", sck_oe, 0);
        chk(sck_o == 1, "R10 sck_o", sck_o, 1);
        chk(so == 1, "R10 so", so, 1);
        chk(rd_data == 0, "R10 rd_data", rd_data, 0);

        run_master(8'hA5, 8'h3C, 1'b0);
        run_master(8'h1E, 8'hC3, 1'b1);
        run_master(8'h00, 8'hFF, 1'b0);

        // R6: write during transfer is dropped and flagged
        cap.delete(); resp = 8'h81; resp_lsb = 0; ridx = 0; resp_on = 1; cap_on = 1;
        wr(1'b1, 8'h05);
        wr(1'b0, 8'h3C);
        repeat (10) @(negedge clk);
        col0 = col_cnt;
        wr(1'b0, 8'hFF);
        chk(wr_collide == 1'b1, "R6 collide pulse", wr_collide, 1);
        @(negedge clk);
        chk(wr_collide == 1'b0, "R6 collide one cycle", wr_collide, 0);
        wait_irq(seen);
        chk(seen, "R6 transfer completes", seen, 1);
        chk(rd_data == 8'h81, "R6 received byte intact", rd_data, 8'h81);
        check_cap(8'h3C, 1'b0, "R6 original bits sent");
        chk(col_cnt == col0 + 1, "R6 single flag", col_cnt, col0 + 1);
        resp_on = 0; cap_on = 0;
        repeat (5) @(negedge clk);

        // R7: abort in mid-byte
        wr(1'b1, 8'h05);
        irq0 = irq_cnt;
        wr(1'b0, 8'hF0);
        repeat (7) @(negedge clk);
        wr(1'b1, 8'h00);
        chk(busy == 1'b0, "R7 busy cleared", busy, 0);
        chk(sck_o == 1'b1, "R7 clock high", sck_o, 1);
        repeat (40) @(negedge clk);
        chk(irq_cnt == irq0, "R7 no irq after abort", irq_cnt, irq0);

        // R9: write with enable clear
        wr(1'b0, 8'h77);
        chk(rd_data == 8'h77, "R9 data loaded", rd_data, 8'h77);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R9 no transfer", busy, 0);
        chk(sck_o == 1'b1, "R9 clock idle", sck_o, 1);
        chk(irq_cnt == irq0, "R9 no irq", irq_cnt, irq0);

        // Slave mode, both orders, and a start with the clock low
        run_slave(8'h5A, 8'h96, 1'b0, 1'b0);
        run_slave(8'hC1, 8'h2D, 1'b1, 1'b0);
        run_slave(8'h93, 8'h6E, 1'b0, 1'b1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule